// File: doc/BRIEF.md
# Fetch Branch Predictor with Return Stack

This block sits beside the instruction fetch stage and tells fetch where to go next. In each cycle fetch presents the address of the block it is reading and a pre-decoded branch kind for that block. The predictor answers in the same cycle with a taken flag and the next fetch address. Jumps, calls and conditional branches are looked up in a direct-mapped target table. Each table entry holds a tag, a stored target and a two-bit saturating history counter. Returns ignore the table and take their target from a small stack of return addresses. A call pushes the address of the next sequential fetch block onto that stack, and a return pops it.

A resolve port from the execute stage sends back each branch's real outcome, together with the prediction it was fetched under. In the same cycle the block raises a mispredict flag and gives the address fetch must restart from. On the next clock edge it trains the table: it allocates an entry when a taken branch missed, moves the history counter, and rewrites the stored target. The pipeline flush itself, instruction decode and the memory side of fetch are handled elsewhere. This block only signals the need to redirect.

Top module: `bpu_fetch_predictor`

## Requirements
- R1: With `fe_valid` high and kind jump (1) or call (3), a table hit gives `pred_taken`=1 and `pred_next` equal to the stored target. A taken resolve of a branch already in the table replaces its stored target.
- R2: With kind conditional (2), a table hit predicts taken with the stored target when bit 1 of the entry's counter is set. Otherwise it predicts not taken with the sequential address.
- R3: A jump, call or conditional branch that misses gives `pred_taken`=0 and the sequential address. A hit needs the valid bit and a matching tag, so an address that shares an index with a stored entry but has a different tag is a miss. Kind none (0) is never taken.
- R4: A resolved conditional branch that hits moves its counter up by one when taken and down by one when not taken. The counter saturates at 3 and at 0.
- R5: Kind return (4) predicts taken to the top of the return stack, whatever the table holds for that address. A fetched call pushes the sequential address of its fetch block, and a fetched return pops. The order is last in, first out.
- R6: The sequential address is the fetch address with its low log2(`LINE_BYTES`) bits cleared, plus `LINE_BYTES` (16 by default).
- R7: A return fetched while the stack is empty predicts not taken with the sequential address, and the stack stays empty.
- R8: The stack holds `RAS_DEPTH` entries (8 by default). A call pushed when the stack is full overwrites the oldest entry, so the most recent `RAS_DEPTH` return addresses stay available in LIFO order.
- R9: With `rs_valid` high, `mispredict` is 1 exactly when `rs_taken` differs from `rs_pred_taken`, or when both are taken and `rs_target` differs from `rs_pred_target`. `fix_addr` is `rs_target` when taken, and otherwise the sequential address of `rs_pc`.
- R10: A resolved taken jump, call or conditional branch that misses allocates its entry with its target and counter value 2 (weakly taken). A not-taken miss allocates nothing.
- R11: Predictions depend only on table and stack state from before the current clock edge. A table update made by a resolve becomes visible to fetch lookups from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fe_valid | input | 1 | Fetch lookup valid this cycle |
| fe_pc | input | AW | Fetch address |
| fe_kind | input | 3 | Pre-decoded kind: 0 none, 1 jump, 2 conditional, 3 call, 4 return |
| pred_taken | output | 1 | Predicted taken |
| pred_next | output | AW | Predicted next fetch address |
| rs_valid | input | 1 | Resolved branch valid |
| rs_pc | input | AW | Address of the resolved branch's fetch block |
| rs_kind | input | 3 | Kind of the resolved branch, same encoding |
| rs_taken | input | 1 | Actual direction |
| rs_target | input | AW | Actual target |
| rs_pred_taken | input | 1 | Direction that was predicted for it |
| rs_pred_target | input | AW | Target that was predicted for it |
| mispredict | output | 1 | Redirect needed |
| fix_addr | output | AW | Correct restart address |

## Verification
The prediction outputs and the mispredict outputs are combinational, so they are due in the same cycle as their inputs. The bench drives inputs just after a falling edge and samples them one nanosecond later, well before the next rising edge. Table training and stack pushes and pops take effect at the following rising edge. The bench therefore checks their effect in the next lookup, one full cycle later. One case drives a resolve and a lookup to the same address together, to show that the lookup still sees the old state. The counter sweep works out each expected direction from a saturating count kept in the bench. The stack sweep works out each expected return from the call addresses it pushed.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

   typedef enum logic [2:0] {
      BK_NONE = 3'd0,
      BK_JUMP = 3'd1,
      BK_COND = 3'd2,
      BK_CALL = 3'd3,
      BK_RET  = 3'd4
   } br_kind_e;

   localparam logic [1:0] CTR_WEAK_TAKEN = 2'b10;

   // two-bit saturating step: up on taken, down on not taken
   function automatic logic [1:0] sat_step(input logic [1:0] c, input logic up);
      if (up) return (c == 2'b11) ? c : c + 2'd1;
      else    return (c == 2'b00) ? c : c - 2'd1;
   endfunction

endpackage

// File: rtl/bpu_target_buf.sv
module bpu_target_buf
   import bpu_pkg::*;
#(
   parameter int AW      = 32,
   parameter int BLK_W   = 28,
   parameter int ENTRIES = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BLK_W-1:0] lk_blk,
   output logic             lk_hit,
   output logic [AW-1:0]    lk_target,
   output logic [1:0]       lk_ctr,
   input  logic             up_en,
   input  logic [BLK_W-1:0] up_blk,
   input  logic             up_is_cond,
   input  logic             up_taken,
   input  logic [AW-1:0]    up_target
);
   localparam int IDX_W = $clog2(ENTRIES);
   localparam int TAG_W = BLK_W - IDX_W;

   if ((ENTRIES < 2) || ((ENTRIES & (ENTRIES - 1)) != 0)) begin : g_bad_entries
      $error("bpu_target_buf: ENTRIES must be a power of two >= 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("bpu_target_buf: block address too narrow for index");
   end

   logic [ENTRIES-1:0] vld_vec;
   logic [TAG_W-1:0]   tag_arr [ENTRIES];
   logic [AW-1:0]      tgt_arr [ENTRIES];
   logic [1:0]         ctr_arr [ENTRIES];

   logic [IDX_W-1:0] lk_idx, up_idx;
   logic [TAG_W-1:0] lk_tag, up_tag;
   logic             up_hit, up_alloc, up_train;

   assign lk_idx = lk_blk[IDX_W-1:0];
   assign lk_tag = lk_blk[BLK_W-1:IDX_W];
   assign up_idx = up_blk[IDX_W-1:0];
   assign up_tag = up_blk[BLK_W-1:IDX_W];

   assign lk_hit    = vld_vec[lk_idx] && (tag_arr[lk_idx] == lk_tag);
   assign lk_target = tgt_arr[lk_idx];
   assign lk_ctr    = ctr_arr[lk_idx];

   assign up_hit   = vld_vec[up_idx] && (tag_arr[up_idx] == up_tag);
   assign up_alloc = up_en && !up_hit && up_taken;
   assign up_train = up_en && up_hit;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic             v_q;
      logic [TAG_W-1:0] tag_q;
      logic [AW-1:0]    tgt_q;
      logic [1:0]       ctr_q;
      logic             sel;

      assign sel = (up_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q   <= 1'b0;
            tag_q <= '0;
            tgt_q <= '0;
            ctr_q <= CTR_WEAK_TAKEN;
         end else if (sel) begin
            if (up_alloc) begin
               v_q   <= 1'b1;
               tag_q <= up_tag;
               tgt_q <= up_target;
               ctr_q <= CTR_WEAK_TAKEN;
            end else if (up_train) begin
               if (up_is_cond) ctr_q <= sat_step(ctr_q, up_taken);
               if (up_taken)   tgt_q <= up_target;
            end
         end
      end

      assign vld_vec[e] = v_q;
      assign tag_arr[e] = tag_q;
      assign tgt_arr[e] = tgt_q;
      assign ctr_arr[e] = ctr_q;
   end

   // R10: a fresh entry starts weakly taken
   p_alloc_weak_r10: assert property (@(posedge clk) disable iff (!rst_n)
      up_alloc |=> (ctr_arr[$past(up_idx)] == CTR_WEAK_TAKEN) && vld_vec[$past(up_idx)]);

   // R10: a not-taken miss leaves the valid bits alone
   p_nt_miss_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (up_en && !up_hit && !up_taken) |=> (vld_vec == $past(vld_vec)));

   // R4: saturation at both ends
   p_ctr_sat_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (up_train && up_is_cond && up_taken && ctr_arr[up_idx] == 2'b11)
      |=> (ctr_arr[$past(up_idx)] == 2'b11));
   p_ctr_sat_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (up_train && up_is_cond && !up_taken && ctr_arr[up_idx] == 2'b00)
      |=> (ctr_arr[$past(up_idx)] == 2'b00));

endmodule

// File: rtl/bpu_ret_stack.sv
module bpu_ret_stack #(
   parameter int AW    = 32,
   parameter int DEPTH = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_addr,
   input  logic          pop,
   output logic          top_valid,
   output logic [AW-1:0] top_addr
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = PW + 1;
   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("bpu_ret_stack: DEPTH must be a power of two >= 2");
   end

   logic [PW-1:0] wr_ptr, top_ptr;
   logic [CW-1:0] fill;
   logic [AW-1:0] slot_arr [DEPTH];

   assign top_ptr   = wr_ptr - PW'(1);
   assign top_valid = (fill != '0);
   assign top_addr  = slot_arr[top_ptr];

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      logic [AW-1:0] a_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            a_q <= '0;
         else if (push && (wr_ptr == PW'(s)))   a_q <= push_addr;
      end
      assign slot_arr[s] = a_q;
   end

   // circular pointer: a push onto a full stack overwrites the oldest slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         fill   <= '0;
      end else if (push) begin
         wr_ptr <= wr_ptr + PW'(1);
         fill   <= (fill == FULL) ? fill : fill + CW'(1);
      end else if (pop && top_valid) begin
         wr_ptr <= top_ptr;
         fill   <= fill - CW'(1);
      end
   end

   p_fill_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FULL);
   p_full_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (push && fill == FULL) |=> (fill == FULL));
   p_push_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (push && fill != FULL) |=> (fill == $past(fill) + CW'(1)));
   p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && fill == '0) |=> (fill == '0) && $stable(wr_ptr));

endmodule

// File: rtl/bpu_fetch_predictor.sv
module bpu_fetch_predictor
   import bpu_pkg::*;
#(
   parameter int AW         = 32,
   parameter int LINE_BYTES = 16,
   parameter int BTB_ENTRIES = 64,
   parameter int RAS_DEPTH  = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fe_valid,
   input  logic [AW-1:0] fe_pc,
   input  logic [2:0]    fe_kind,
   output logic          pred_taken,
   output logic [AW-1:0] pred_next,
   input  logic          rs_valid,
   input  logic [AW-1:0] rs_pc,
   input  logic [2:0]    rs_kind,
   input  logic          rs_taken,
   input  logic [AW-1:0] rs_target,
   input  logic          rs_pred_taken,
   input  logic [AW-1:0] rs_pred_target,
   output logic          mispredict,
   output logic [AW-1:0] fix_addr
);
   localparam int OFF_W = $clog2(LINE_BYTES);
   localparam int BLK_W = AW - OFF_W;

   if ((LINE_BYTES < 2) || ((LINE_BYTES & (LINE_BYTES - 1)) != 0)) begin : g_bad_line
      $error("bpu_fetch_predictor: LINE_BYTES must be a power of two >= 2");
   end

   br_kind_e fk, rk;
   assign fk = br_kind_e'(fe_kind);
   assign rk = br_kind_e'(rs_kind);

   logic [BLK_W-1:0] fe_blk, rs_blk;
   logic [AW-1:0]    fe_seq, rs_seq;
   logic             unused_low;

   assign fe_blk     = fe_pc[AW-1:OFF_W];
   assign rs_blk     = rs_pc[AW-1:OFF_W];
   assign fe_seq     = {fe_blk + BLK_W'(1), {OFF_W{1'b0}}};
   assign rs_seq     = {rs_blk + BLK_W'(1), {OFF_W{1'b0}}};
   assign unused_low = ^{fe_pc[OFF_W-1:0], rs_pc[OFF_W-1:0]};

   // target table
   logic          tb_hit;
   logic [AW-1:0] tb_target;
   logic [1:0]    tb_ctr;
   logic          up_en, up_is_cond;

   assign up_en      = rs_valid && (rk == BK_JUMP || rk == BK_COND || rk == BK_CALL);
   assign up_is_cond = (rk == BK_COND);

   bpu_target_buf #(.AW(AW), .BLK_W(BLK_W), .ENTRIES(BTB_ENTRIES)) u_tbuf (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_blk     (fe_blk),
      .lk_hit     (tb_hit),
      .lk_target  (tb_target),
      .lk_ctr     (tb_ctr),
      .up_en      (up_en),
      .up_blk     (rs_blk),
      .up_is_cond (up_is_cond),
      .up_taken   (rs_taken),
      .up_target  (rs_target)
   );

   // return stack
   logic          rst_push, rst_pop, rst_top_v;
   logic [AW-1:0] rst_top;

   assign rst_push = fe_valid && (fk == BK_CALL);
   assign rst_pop  = fe_valid && (fk == BK_RET);

   bpu_ret_stack #(.AW(AW), .DEPTH(RAS_DEPTH)) u_rstk (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (rst_push),
      .push_addr (fe_seq),
      .pop       (rst_pop),
      .top_valid (rst_top_v),
      .top_addr  (rst_top)
   );

   // prediction select
   always_comb begin
      pred_taken = 1'b0;
      pred_next  = fe_seq;
      if (fe_valid) begin
         unique case (fk)
            BK_RET: begin
               if (rst_top_v) begin
                  pred_taken = 1'b1;
                  pred_next  = rst_top;
               end
            end
            BK_JUMP, BK_CALL: begin
               if (tb_hit) begin
                  pred_taken = 1'b1;
                  pred_next  = tb_target;
               end
            end
            BK_COND: begin
               if (tb_hit && tb_ctr[1]) begin
                  pred_taken = 1'b1;
                  pred_next  = tb_target;
               end
            end
            default: ;
         endcase
      end
   end

   // resolve compare
   assign mispredict = rs_valid &&
                       ((rs_taken != rs_pred_taken) ||
                        (rs_taken && (rs_target != rs_pred_target)));
   assign fix_addr   = rs_taken ? rs_target : rs_seq;

   p_uncond_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (fe_valid && (fk == BK_JUMP || fk == BK_CALL) && tb_hit) |-> pred_taken);
   p_cond_miss_nt_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fe_valid && fk != BK_RET && !tb_hit) |-> !pred_taken);
   p_ret_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fe_valid && fk == BK_RET && !rst_top_v) |-> !pred_taken);
   p_seq_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_taken |-> (pred_next[OFF_W-1:0] == '0));
   p_match_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_taken == rs_pred_taken && (!rs_taken || rs_target == rs_pred_target))
      |-> !mispredict);

endmodule

// File: tb/bpu_fetch_predictor_tb.sv
`timescale 1ns/1ps
module bpu_fetch_predictor_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fe_valid = 1'b0;
   logic [31:0] fe_pc = '0;
   logic [2:0]  fe_kind = '0;
   logic        pred_taken;
   logic [31:0] pred_next;
   logic        rs_valid = 1'b0;
   logic [31:0] rs_pc = '0;
   logic [2:0]  rs_kind = '0;
   logic        rs_taken = 1'b0;
   logic [31:0] rs_target = '0;
   logic        rs_pred_taken = 1'b0;
   logic [31:0] rs_pred_target = '0;
   logic        mispredict;
   logic [31:0] fix_addr;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   localparam logic [2:0] K_NONE = 3'd0, K_JMP = 3'd1, K_CND = 3'd2, K_CAL = 3'd3, K_RET = 3'd4;

   always #2 clk = ~clk;

   bpu_fetch_predictor u_dut (
      .clk(clk), .rst_n(rst_n),
      .fe_valid(fe_valid), .fe_pc(fe_pc), .fe_kind(fe_kind),
      .pred_taken(pred_taken), .pred_next(pred_next),
      .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_kind(rs_kind), .rs_taken(rs_taken),
      .rs_target(rs_target), .rs_pred_taken(rs_pred_taken), .rs_pred_target(rs_pred_target),
      .mispredict(mispredict), .fix_addr(fix_addr)
   );

   function automatic logic [31:0] seq(input logic [31:0] pc);
      return (pc & ~32'hF) + 32'd16;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // called just after a falling edge
   task automatic fetch(input logic [31:0] pc, input logic [2:0] k,
                        input logic exp_t, input logic [31:0] exp_n, input string req);
      fe_valid = 1'b1; fe_pc = pc; fe_kind = k;
      #1;
      check({req, " taken"}, {31'd0, pred_taken}, {31'd0, exp_t});
      check({req, " next"}, pred_next, exp_n);
      @(posedge clk); @(negedge clk);
      fe_valid = 1'b0;
   endtask

   task automatic resolve(input logic [31:0] pc, input logic [2:0] k, input logic t,
                          input logic [31:0] tgt, input logic pt, input logic [31:0] ptgt,
                          input logic exp_mp, input string req);
      rs_valid = 1'b1; rs_pc = pc; rs_kind = k; rs_taken = t; rs_target = tgt;
      rs_pred_taken = pt; rs_pred_target = ptgt;
      #1;
      check({req, " mispredict"}, {31'd0, mispredict}, {31'd0, exp_mp});
      if (exp_mp) check({req, " fix"}, fix_addr, t ? tgt : seq(pc));
      @(posedge clk); @(negedge clk);
      rs_valid = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] A, B, C, D, E, q;
      int c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      #1;
      check("R3 reset taken", {31'd0, pred_taken}, 32'd0);
      check("R9 reset mispredict", {31'd0, mispredict}, 32'd0);
      @(negedge clk);
      fetch(32'h0000_0123, K_RET, 1'b0, 32'h0000_0130, "R7 empty return after reset");

      // R3/R6 sweep over cold table
      for (int i = 0; i < 64; i++) begin
         logic [31:0] p;
         p = 32'h0000_4000 + i * 16 + (i % 16);
         fetch(p, 3'(i % 3), 1'b0, seq(p), "R3 R6 cold sweep");
      end

      // R1 jump alloc and hit
      A = 32'h0000_8040;
      resolve(A, K_JMP, 1'b1, 32'h0000_9000, 1'b0, 32'h0, 1'b1, "R9 taken miss");
      fetch(A + 5, K_JMP, 1'b1, 32'h0000_9000, "R1 jump hit");
      B = 32'h0000_8080;
      resolve(B, K_CAL, 1'b1, 32'h0000_A000, 1'b0, 32'h0, 1'b1, "R10 call alloc");
      fetch(B, K_CAL, 1'b1, 32'h0000_A000, "R1 call hit");
      // R5 return uses stack even where the table hits
      fetch(A, K_RET, 1'b1, seq(B), "R5 return from stack");
      fetch(A, K_RET, 1'b0, seq(A), "R7 empty return");

      // R10 not-taken miss allocates nothing
      C = 32'h0000_80C0;
      resolve(C, K_CND, 1'b0, 32'h0000_7000, 1'b0, 32'h0, 1'b0, "R9 nt match");
      fetch(C, K_CND, 1'b0, seq(C), "R10 no alloc on nt");

      // R10 weakly taken, then R4/R2 counter sweep
      D = 32'h0000_8100;
      resolve(D, K_CND, 1'b1, 32'h0000_B000, 1'b0, 32'h0, 1'b1, "R10 cond alloc");
      fetch(D, K_CND, 1'b1, 32'h0000_B000, "R10 weakly taken");
      c = 2;
      for (int j = 0; j < 8; j++) begin
         logic o;
         o = (j >= 3 && j <= 6);
         resolve(D, K_CND, o, 32'h0000_B000, (c >= 2), 32'h0000_B000, (o != (c >= 2)), "R4 train");
         c = o ? ((c == 3) ? 3 : c + 1) : ((c == 0) ? 0 : c - 1);
         fetch(D, K_CND, (c >= 2), (c >= 2) ? 32'h0000_B000 : seq(D), "R2 R4 counter");
      end
      fetch(D + 32'd1024, K_CND, 1'b0, seq(D + 32'd1024), "R3 tag alias");

      // R9 compare cases and R1 retarget
      resolve(A, K_JMP, 1'b1, 32'h0000_9000, 1'b1, 32'h0000_9000, 1'b0, "R9 full match");
      resolve(A, K_JMP, 1'b1, 32'h0000_9000, 1'b1, 32'h0000_9100, 1'b1, "R9 target differs");
      resolve(32'h0000_6007, K_NONE, 1'b0, 32'h0, 1'b1, 32'h0000_7000, 1'b1, "R9 false taken");
      resolve(A, K_JMP, 1'b1, 32'h0000_9400, 1'b1, 32'h0000_9000, 1'b1, "R9 retarget");
      fetch(A, K_JMP, 1'b1, 32'h0000_9400, "R1 retarget visible");

      // R11 same-cycle resolve and lookup
      E = 32'h0000_8200;
      rs_valid = 1'b1; rs_pc = E; rs_kind = K_CND; rs_taken = 1'b1; rs_target = 32'h0000_C000;
      rs_pred_taken = 1'b0; rs_pred_target = '0;
      fe_valid = 1'b1; fe_pc = E; fe_kind = K_CND;
      #1;
      check("R11 old state seen", {31'd0, pred_taken}, 32'd0);
      @(posedge clk); @(negedge clk);
      rs_valid = 1'b0;
      #1;
      check("R11 update next cycle", pred_next, 32'h0000_C000);
      @(posedge clk); @(negedge clk);
      fe_valid = 1'b0;

      // R8 overflow drops oldest
      for (int k = 0; k < 10; k++) begin
         q = 32'h0002_0000 + k * 32'h100;
         fetch(q, K_CAL, 1'b0, seq(q), "R8 call push");
      end
      for (int k = 9; k >= 2; k--) begin
         q = 32'h0002_0000 + k * 32'h100;
         fetch(32'h0003_0000, K_RET, 1'b1, seq(q), "R8 R5 lifo return");
      end
      fetch(32'h0003_0000, K_RET, 1'b0, 32'h0003_0010, "R8 R7 oldest dropped");

      done = 1;
      summary();
      $finish;
   end
endmodule